// File: doc/BRIEF.md
# Fault-Stealing Logical Index Mapper

The mapper assigns a logical (row, column) position to every physical processing cell of a small rectangular array that carries one spare column on its right edge and one spare row along its bottom. Given a per-cell fault bitmap, it repairs the array globally. Each nominal row shifts right past one of its blocked cells and uses the spare column to do so. Every other blocked cell in that row is covered by borrowing ("stealing") the cell directly below it. A borrowed cell then counts as blocked when its own row is mapped.

A start strobe captures the fault bitmap and a mode bit. The mode bit selects between a fixed rule and a variable rule for choosing which blocked cell the row shift repairs. The mapper then walks the nominal rows top to bottom, one row per clock cycle, and raises done one cycle after the last row. A fatal flag reports a fault pattern that cannot be repaired. The switch settings of the array are meant to be derived downstream from the index map.

Top module: `fsteal_mapper`

## Requirements
- R1: A start pulse seen while the mapper is idle is taken at clock edge E0. It clears done and fatal. Nominal rows 0..ROWS-1 are mapped at edges E1..E(ROWS). done rises after edge E(ROWS+1) and stays high until the next accepted start.
- R2: Physical cells are addressed by 0-based (r, c). The fault bit is `fault_map[r*(COLS+1)+c]`, and the index fields are `lrow_o`/`lcol_o` at bit offset `(r*(COLS+1)+c)*width`. Logical indices are 1-based. When no cell is faulty, every nominal cell gets (r+1, c+1), and every cell of the spare row and spare column gets (0, 0).
- R3: A faulty cell that is not borrowed, and any spare cell left unused, reads (0, 0). Outside a fatal result, each cell has either both indices zero or both indices non-zero.
- R4: In a row whose blocked columns are non-empty, call the column repaired by the shift the repair column h. Unblocked cells left of h get logical column c+1. Unblocked cells right of h get logical column c (shifted by one). All of them get logical row r+1.
- R5: With mode=0 (fixed rule), h is the rightmost blocked column. Each other blocked column k lends cell (r+1, k), which gets logical indices (r+1, k+1).
- R6: A cell borrowed by the row above counts as blocked when its own row is mapped, and it keeps the indices the row above gave it.
- R7: With mode=0, fatal is raised when any cell that must be borrowed is itself faulty.
- R8: With mode=1 (variable rule), h is the rightmost blocked column whose lower neighbour is faulty, or the rightmost blocked column if there is none. A borrowed cell under column k gets logical column k+1 when k<h and k when k>h.
- R9: With mode=1, fatal is raised only when two or more blocked columns of a row have a faulty lower neighbour.
- R10: The fault map and mode are captured at start. A start pulse, fault-map change or mode change while mapping is in progress has no effect on the result or on the done timing.
- R11: The spare row never borrows. Its cells get non-zero indices only when the last nominal row borrows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a mapping pass (taken when idle) |
| mode | input | 1 | 0 = fixed rule, 1 = variable rule |
| fault_map | input | (ROWS+1)*(COLS+1) | One fault bit per physical cell |
| lrow_o | output | (ROWS+1)*(COLS+1)*RW | Logical row per cell, 0 = unused |
| lcol_o | output | (ROWS+1)*(COLS+1)*CW | Logical column per cell, 0 = unused |
| done | output | 1 | Mapping finished |
| fatal | output | 1 | Fault pattern not repairable |

## Verification
The bench builds the mapper with four nominal rows and five nominal columns, a 5×6 physical grid. Because the grid is not square, a swapped row/column index shows up at once. Five rows give enough depth for borrowing to cascade over two rows and for the last nominal row to borrow from the spare row. Six columns leave room for blocked columns on both sides of a variable-rule repair column and for a fault confined to the spare column.

// File: rtl/fsteal_pkg.sv
package fsteal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fsteal_state_e;

  // Logical column (1-based) given to physical column j (0-based)
  // once the row shift repairs column h.
  function automatic int shifted_col(input int j, input int h);
    return (j < h) ? (j + 1) : j;
  endfunction

endpackage

// File: rtl/fsteal_pick.sv
module fsteal_pick #(
  parameter int NC = 6,
  parameter int CW = 3
) (
  input  logic [NC-1:0] blk,
  input  logic [NC-1:0] below,
  input  logic          mode_var,
  output logic [CW-1:0] h,
  output logic          fatal_row
);
  logic [NC-1:0] hit;
  logic [NC-1:0] hmask;
  logic [CW-1:0] right_blk;
  logic [CW-1:0] right_hit;
  logic          has_hit;

  assign hit     = blk & below;
  assign has_hit = |hit;

  always_comb begin
    right_blk = CW'(NC - 1);
    right_hit = '0;
    for (int j = 0; j < NC; j++) begin
      if (blk[j]) right_blk = CW'(j);
      if (hit[j]) right_hit = CW'(j);
    end
  end

  assign h = (mode_var && has_hit) ? right_hit : right_blk;

  always_comb begin
    hmask = '0;
    hmask[h] = 1'b1;
  end

  // Any faulty cell that would have to be borrowed (all blocked columns other than h).
  assign fatal_row = |(hit & ~hmask);

endmodule

// File: rtl/fsteal_rowmap.sv
module fsteal_rowmap #(
  parameter int NC = 6,
  parameter int CW = 3
) (
  input  logic [NC-1:0]    blk,
  input  logic [CW-1:0]    h,
  output logic [NC-1:0]    use_cur,
  output logic [NC-1:0]    steal_nxt,
  output logic [NC*CW-1:0] col_val
);
  import fsteal_pkg::*;

  for (genvar j = 0; j < NC; j++) begin : g_col
    logic is_h;
    logic left_of_h;
    assign is_h         = (CW'(j) == h);
    assign left_of_h    = (CW'(j) < h);
    assign use_cur[j]   = ~blk[j] & ~is_h;
    assign steal_nxt[j] = blk[j] & ~is_h;
    assign col_val[j*CW +: CW] = left_of_h ? CW'(shifted_col(j, j + 1)) : CW'(j);
  end

endmodule

// File: rtl/fsteal_ctrl.sv
module fsteal_ctrl #(
  parameter int ROWS = 4,
  parameter int RW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          run,
  output logic          last_step,
  output logic          fin,
  output logic [RW-1:0] row
);
  import fsteal_pkg::*;

  fsteal_state_e state_q;
  logic [RW-1:0] row_q;

  assign launch    = start && (state_q == ST_IDLE);
  assign run       = (state_q == ST_RUN);
  assign fin       = (state_q == ST_FIN);
  assign last_step = run && (row_q == RW'(ROWS - 1));
  assign row       = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          row_q   <= '0;
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FIN;
          else           row_q   <= row_q + RW'(1);
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fsteal_mapper.sv
module fsteal_mapper #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NR    = ROWS + 1,
  localparam int NC    = COLS + 1,
  localparam int NCELL = NR * NC,
  localparam int RW    = $clog2(ROWS + 2),
  localparam int CW    = $clog2(COLS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode,
  input  logic [NCELL-1:0]    fault_map,
  output logic [NCELL*RW-1:0] lrow_o,
  output logic [NCELL*CW-1:0] lcol_o,
  output logic                done,
  output logic                fatal
);
  localparam int FW = $clog2(NCELL + 1);

  logic [NCELL-1:0] fault_q;
  logic             mode_q;
  logic [NC-1:0]    steal_q;
  logic [RW-1:0]    lrow_q [NCELL];
  logic [CW-1:0]    lcol_q [NCELL];
  logic             done_q;
  logic             fatal_q;

  // Named internal events
  logic          launch;
  logic          run;
  logic          last_step;
  logic          fin;
  logic [RW-1:0] row;
  logic [FW-1:0] base;
  logic [RW-1:0] row_lv;
  logic [NC-1:0] cur_flt;
  logic [NC-1:0] below_flt;
  logic [NC-1:0] blk;
  logic [CW-1:0] h;
  logic          row_fatal;
  logic [NC-1:0] use_cur;
  logic [NC-1:0] steal_nxt;
  logic [NC*CW-1:0] col_val;

  fsteal_ctrl #(.ROWS(ROWS), .RW(RW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .launch    (launch),
    .run       (run),
    .last_step (last_step),
    .fin       (fin),
    .row       (row)
  );

  assign base      = FW'(row) * FW'(NC);
  assign row_lv    = row + RW'(1);
  assign cur_flt   = fault_q[base +: NC];
  assign below_flt = fault_q[base + FW'(NC) +: NC];
  assign blk       = cur_flt | steal_q;

  fsteal_pick #(.NC(NC), .CW(CW)) u_pick (
    .blk       (blk),
    .below     (below_flt),
    .mode_var  (mode_q),
    .h         (h),
    .fatal_row (row_fatal)
  );

  fsteal_rowmap #(.NC(NC), .CW(CW)) u_rowmap (
    .blk       (blk),
    .h         (h),
    .use_cur   (use_cur),
    .steal_nxt (steal_nxt),
    .col_val   (col_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0;
      mode_q  <= 1'b0;
      steal_q <= '0;
      done_q  <= 1'b0;
      fatal_q <= 1'b0;
      for (int p = 0; p < NCELL; p++) begin
        lrow_q[p] <= '0;
        lcol_q[p] <= '0;
      end
    end else if (launch) begin
      fault_q <= fault_map;
      mode_q  <= mode;
      steal_q <= '0;
      done_q  <= 1'b0;
      fatal_q <= 1'b0;
      for (int p = 0; p < NCELL; p++) begin
        lrow_q[p] <= '0;
        lcol_q[p] <= '0;
      end
    end else if (run) begin
      for (int c = 0; c < NC; c++) begin
        if (use_cur[c]) begin
          lrow_q[base + FW'(c)] <= row_lv;
          lcol_q[base + FW'(c)] <= col_val[c*CW +: CW];
        end
        if (steal_nxt[c]) begin
          lrow_q[base + FW'(NC + c)] <= row_lv;
          lcol_q[base + FW'(NC + c)] <= col_val[c*CW +: CW];
        end
      end
      steal_q <= steal_nxt;
      if (row_fatal) fatal_q <= 1'b1;
    end else if (fin) begin
      done_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NCELL; p++) begin : g_out
    assign lrow_o[p*RW +: RW] = lrow_q[p];
    assign lcol_o[p*CW +: CW] = lcol_q[p];
  end

  assign done  = done_q;
  assign fatal = fatal_q;

endmodule

// File: rtl/fsteal_mapper_chk.sv
module fsteal_mapper_chk #(
  parameter int NCELL = 30,
  parameter int RW    = 3,
  parameter int CW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                launch,
  input logic                run,
  input logic                last_step,
  input logic                fin,
  input logic                done,
  input logic                fatal,
  input logic [NCELL*RW-1:0] lrow_o,
  input logic [NCELL*CW-1:0] lcol_o
);

  assert_done_after_fin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  assert_last_then_fin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> fin);

  assert_no_done_while_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !done);

  assert_launch_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done && !fatal));

  assert_run_continues_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_step) |=> run);

  assert_fatal_in_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal) |-> $past(run));

  for (genvar p = 0; p < NCELL; p++) begin : g_cell
    assert_pair_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fatal) |-> ((lrow_o[p*RW +: RW] == '0) == (lcol_o[p*CW +: CW] == '0)));
  end

endmodule

bind fsteal_mapper fsteal_mapper_chk #(.NCELL(NCELL), .RW(RW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .launch    (launch),
  .run       (run),
  .last_step (last_step),
  .fin       (fin),
  .done      (done),
  .fatal     (fatal),
  .lrow_o    (lrow_o),
  .lcol_o    (lcol_o)
);

// File: tb/fsteal_mapper_tb.sv
`timescale 1ns/1ps
module fsteal_mapper_tb;
  localparam int ROWS  = 4;
  localparam int COLS  = 5;
  localparam int NR    = ROWS + 1;
  localparam int NC    = COLS + 1;
  localparam int NCELL = NR * NC;
  localparam int RW    = $clog2(ROWS + 2);
  localparam int CW    = $clog2(COLS + 2);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                mode = 1'b0;
  logic [NCELL-1:0]    fault_map = '0;
  logic [NCELL*RW-1:0] lrow_o;
  logic [NCELL*CW-1:0] lcol_o;
  logic                done;
  logic                fatal;

  int checks = 0;
  int errors = 0;

  int exp_r [NR][NC];
  int exp_c [NR][NC];
  bit exp_fatal;

  always #5 clk = ~clk;

  fsteal_mapper #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .fault_map(fault_map), .lrow_o(lrow_o), .lcol_o(lcol_o),
    .done(done), .fatal(fatal)
  );

  function automatic int got_r(int r, int c);
    return int'(lrow_o[(r*NC+c)*RW +: RW]);
  endfunction
  function automatic int got_c(int r, int c);
    return int'(lcol_o[(r*NC+c)*CW +: CW]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: blocked columns kept in a queue per row.
  task automatic model(input logic [NCELL-1:0] m, input bit md);
    bit bad [NR][NC];
    bit lent [NR][NC];
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        bad[r][c]  = m[r*NC+c];
        lent[r][c] = 0;
        exp_r[r][c] = 0;
        exp_c[r][c] = 0;
      end
    exp_fatal = 0;
    for (int r = 0; r < ROWS; r++) begin
      int q[$];
      int hc;
      int hits;
      q = {};
      for (int c = 0; c < NC; c++) if (bad[r][c] || lent[r][c]) q.push_back(c);
      if (q.size() == 0) begin
        for (int c = 0; c < COLS; c++) begin
          exp_r[r][c] = r + 1;
          exp_c[r][c] = c + 1;
        end
      end else begin
        hc = q[q.size()-1];
        hits = 0;
        foreach (q[i]) if (bad[r+1][q[i]]) hits++;
        if (md) begin
          foreach (q[i]) if (bad[r+1][q[i]]) hc = q[i];
          if (hits >= 2) exp_fatal = 1;
        end else begin
          foreach (q[i]) if (q[i] != hc && bad[r+1][q[i]]) exp_fatal = 1;
        end
        for (int c = 0; c < NC; c++) begin
          if (!(bad[r][c] || lent[r][c])) begin
            exp_r[r][c] = r + 1;
            exp_c[r][c] = (c < hc) ? c + 1 : c;
          end
        end
        foreach (q[i]) if (q[i] != hc) begin
          lent[r+1][q[i]] = 1;
          exp_r[r+1][q[i]] = r + 1;
          exp_c[r+1][q[i]] = (q[i] < hc) ? q[i] + 1 : q[i];
        end
      end
    end
  endtask

  task automatic run_case(input logic [NCELL-1:0] m, input bit md, input string req, input bit poke);
    int bad_cells;
    model(m, md);
    @(negedge clk);
    fault_map = m;
    mode = md;
    start = 1'b1;
    for (int k = 0; k <= ROWS + 1; k++) begin
      @(posedge clk);
      #1;
      start = (poke && k == 1) ? 1'b1 : 1'b0;
      if (poke && k == 1) begin
        fault_map = ~m;
        mode = ~md;
      end
      chk(done == (k == ROWS + 1), {"R1 done timing ", req}, int'(done), int'(k == ROWS + 1));
    end
    chk(fatal == exp_fatal, {"R7/R9 fatal ", req}, int'(fatal), int'(exp_fatal));
    if (!exp_fatal) begin
      bad_cells = 0;
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++)
          if (got_r(r, c) != exp_r[r][c] || got_c(r, c) != exp_c[r][c]) begin
            bad_cells++;
            $display("FAIL %s cell(%0d,%0d) actual=(%0d,%0d) expected=(%0d,%0d)",
                     req, r, c, got_r(r, c), got_c(r, c), exp_r[r][c], exp_c[r][c]);
          end
      checks++;
      if (bad_cells != 0) errors++;
    end
    @(posedge clk);
    #1;
    chk(done == 1'b1, {"R1 done held ", req}, int'(done), 1);
  endtask

  function automatic logic [NCELL-1:0] bitof(int r, int c);
    logic [NCELL-1:0] v;
    v = '0;
    v[r*NC+c] = 1'b1;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [NCELL-1:0] m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(fatal == 1'b0, "R1 reset fatal", int'(fatal), 0);
    chk(lrow_o == '0 && lcol_o == '0, "R3 reset indices", int'(|lrow_o), 0);

    run_case('0, 1'b0, "R2 no faults", 1'b0);
    run_case(bitof(0,2) | bitof(1,0) | bitof(3,4), 1'b0, "R4 single per row", 1'b0);
    run_case(bitof(0,1) | bitof(0,3), 1'b0, "R5 fixed steal", 1'b0);
    run_case(bitof(0,1) | bitof(0,3) | bitof(1,1), 1'b0, "R7 fixed fatal", 1'b0);
    run_case(bitof(0,1) | bitof(0,3) | bitof(1,1), 1'b1, "R8 variable repair left", 1'b0);
    run_case(bitof(0,1) | bitof(0,3) | bitof(1,1) | bitof(1,3), 1'b1, "R9 variable fatal", 1'b0);
    run_case(bitof(0,0) | bitof(0,2) | bitof(1,4), 1'b0, "R6 cascade", 1'b0);
    run_case(bitof(3,0) | bitof(3,2) | bitof(3,4), 1'b0, "R11 spare row lent", 1'b0);
    run_case(bitof(4,1) | bitof(4,3) | bitof(2,5), 1'b1, "R11 spare faults only", 1'b0);
    run_case(bitof(0,2) | bitof(0,4) | bitof(2,1), 1'b0, "R10 start during run", 1'b1);

    lfsr = 32'h1ACE_B00C;
    for (int t = 0; t < 40; t++) begin
      m = '0;
      for (int b = 0; b < NCELL; b++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[2:0] == 3'd0) m[b] = 1'b1;
      end
      run_case(m, t[0], t[0] ? "R8 random variable" : "R5 random fixed", 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule